// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block steps a DMA channel through the bus states of repeated transfers in demand and block modes. Each transfer uses some of the states S1, S2, S3, SW and S4. S1 strobes the middle address byte into its external latch. It runs on the first transfer of a run. After that it runs only when the previous transfer's address step carried or borrowed out of the low byte. A transfer that changes only low-order address bits starts directly in S2.

Normal timing runs S2, S3, one or more SW states and then S4. A programmable wait count adds more SW states. Compressed timing drops S3, raises both command strobes in S2 and moves terminal count into S2. Memory-to-memory transfers always fall back to normal timing. The address and remaining count are held outside the block. The block pulses `step_o` in S4 so that the channel logic can advance them.

Top module: `dma_xfer_seq`

## Requirements
- R1: During and after reset, until a request arrives, `state_o` is idle and all strobes are low. The state codes are idle=0, S1=1, S2=2, S3=3, SW=4, S4=5.
- R2: A request seen in idle starts a run. The first transfer of every run begins with S1, and `addr_stb_o` is high only in S1.
- R3: A later transfer begins with S1 only if the previous transfer's address had low byte 0xFF while counting up, or 0x00 while counting down (`addr_down_i`=1). Any other later transfer begins in S2.
- R4: Normal timing follows S2, S3, SW..., S4. `rd_cmd_o` is high in S2, S3 and SW. `wr_cmd_o` is high in S3 and SW. Neither strobe is high in S4.
- R5: Each transfer spends exactly `wait_i`+1 cycles in SW. `wait_i` is sampled in the cycle before SW is entered.
- R6: With `compress_i`=1 and `mem2mem_i`=0, a transfer follows S2, SW..., S4 with no S3, and both command strobes are high in S2 and SW.
- R7: With `mem2mem_i`=1, `compress_i` has no effect and normal timing is used.
- R8: The final transfer is the one whose `count_i` is 0 in S2. `tc_o` is high for one cycle during that transfer: in S4 under normal timing, in S2 under compressed timing.
- R9: `step_o` is high for exactly the S4 cycle of each transfer.
- R10: In block mode (`block_mode_i`=1) the run continues whatever the value of `req_i` and returns to idle after the final transfer's S4.
- R11: In demand mode the sequencer returns to idle after S4 if `req_i` is low or the transfer was the final one. Otherwise it starts the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| block_mode_i | input | 1 | 1 = block mode, 0 = demand mode |
| mem2mem_i | input | 1 | Memory-to-memory transfer, forces normal timing |
| compress_i | input | 1 | Compressed timing enable |
| addr_down_i | input | 1 | Address counts down when 1 |
| wait_i | input | WW | Extra wait states |
| addr_i | input | AW | Current transfer address |
| count_i | input | CW | Remaining transfers minus one |
| state_o | output | 3 | Current state code |
| addr_stb_o | output | 1 | Middle address byte latch strobe |
| rd_cmd_o | output | 1 | Read command strobe |
| wr_cmd_o | output | 1 | Write command strobe |
| tc_o | output | 1 | Terminal count |
| step_o | output | 1 | Advance address and count |

## Verification
The hardest case to reach is an S1 inserted in the middle of a run. It needs an address low byte that wraps while more transfers remain. The bench starts runs at 0x12FD counting up and at 0x1302 counting down, so that the third transfer crosses the byte boundary. It sweeps these runs over wait counts, both timing modes, both directions and both run modes. The bench acts as the channel registers: it advances the address and count on each `step_o` and predicts every state cycle by cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_SW   = 3'd4,
    ST_S4   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dma_seq_wait.sv
module dma_seq_wait #(
  parameter int WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] ws_i,
  output logic          zero_o
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= ws_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dma_seq_track.sv
module dma_seq_track #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          s2_i,
  input  logic          down_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  output logic          need_s1_o,
  output logic          last_o,
  output logic          last_now_o
);
  logic need_q, last_q, wrap;

  // low byte carries or borrows into bit 8 on the coming step
  assign wrap       = down_i ? (addr_i[7:0] == 8'h00) : (addr_i[7:0] == 8'hFF);
  assign last_now_o = (count_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      need_q <= 1'b1;
      last_q <= 1'b0;
    end else if (idle_i) begin
      need_q <= 1'b1;
      last_q <= 1'b0;
    end else if (s2_i) begin
      need_q <= wrap;
      last_q <= last_now_o;
    end
  end

  assign need_s1_o = need_q;
  assign last_o    = last_q;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       block_i,
  input  logic       comp_i,
  input  logic       need_s1_i,
  input  logic       last_i,
  input  logic       wait_zero_i,
  output seq_state_e state_o,
  output logic       wait_load_o
);
  seq_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_n = ST_S1;
      ST_S1:   state_n = ST_S2;
      ST_S2:   state_n = comp_i ? ST_SW : ST_S3;
      ST_S3:   state_n = ST_SW;
      ST_SW:   if (wait_zero_i) state_n = ST_S4;
      ST_S4: begin
        if (last_i || !(block_i || req_i)) state_n = ST_IDLE;
        else state_n = need_s1_i ? ST_S1 : ST_S2;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_n;
  end

  assign wait_load_o = (state_n == ST_SW) && (state_q != ST_SW);
  assign state_o     = state_q;
endmodule

// File: rtl/dma_seq_out.sv
module dma_seq_out
  import dma_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       comp_i,
  input  logic       last_i,
  input  logic       last_now_i,
  output logic       addr_stb_o,
  output logic       rd_cmd_o,
  output logic       wr_cmd_o,
  output logic       tc_o,
  output logic       step_o
);
  logic in_s2, in_mid;

  assign in_s2      = (state_i == ST_S2);
  assign in_mid     = (state_i == ST_S3) || (state_i == ST_SW);
  assign addr_stb_o = (state_i == ST_S1);
  assign rd_cmd_o   = in_s2 || in_mid;
  assign wr_cmd_o   = in_mid || (in_s2 && comp_i);
  assign tc_o       = (in_s2 && comp_i && last_now_i) ||
                      ((state_i == ST_S4) && !comp_i && last_i);
  assign step_o     = (state_i == ST_S4);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          block_mode_i,
  input  logic          mem2mem_i,
  input  logic          compress_i,
  input  logic          addr_down_i,
  input  logic [WW-1:0] wait_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  output logic [2:0]    state_o,
  output logic          addr_stb_o,
  output logic          rd_cmd_o,
  output logic          wr_cmd_o,
  output logic          tc_o,
  output logic          step_o
);
  seq_state_e state;
  logic comp_eff, need_s1, last, last_now, wait_load, wait_zero;

  assign comp_eff = compress_i && !mem2mem_i;

  dma_seq_track #(.AW(AW), .CW(CW)) i_track (
    .clk_i, .rst_ni,
    .idle_i     (state == ST_IDLE),
    .s2_i       (state == ST_S2),
    .down_i     (addr_down_i),
    .addr_i, .count_i,
    .need_s1_o  (need_s1),
    .last_o     (last),
    .last_now_o (last_now)
  );

  dma_seq_wait #(.WW(WW)) i_wait (
    .clk_i, .rst_ni,
    .load_i (wait_load),
    .ws_i   (wait_i),
    .zero_o (wait_zero)
  );

  dma_seq_fsm i_fsm (
    .clk_i, .rst_ni,
    .req_i, .block_i(block_mode_i), .comp_i(comp_eff),
    .need_s1_i(need_s1), .last_i(last), .wait_zero_i(wait_zero),
    .state_o(state), .wait_load_o(wait_load)
  );

  dma_seq_out i_out (
    .state_i(state), .comp_i(comp_eff), .last_i(last), .last_now_i(last_now),
    .addr_stb_o, .rd_cmd_o, .wr_cmd_o, .tc_o, .step_o
  );

  assign state_o = state;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int WW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          mem2mem_i,
  input logic          compress_i,
  input logic [WW-1:0] wait_i,
  input logic [2:0]    state_o,
  input logic          addr_stb_o,
  input logic          rd_cmd_o,
  input logic          wr_cmd_o,
  input logic          tc_o,
  input logic          step_o
);
  logic [WW:0]   sw_len_q;
  logic [WW-1:0] ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_len_q <= '0;
      ws_q     <= '0;
    end else begin
      sw_len_q <= (state_o == 3'd4) ? sw_len_q + 1'b1 : '0;
      if (state_o != 3'd4) ws_q <= wait_i;
    end
  end

  AST_START_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && req_i) |=> (state_o == 3'd1 && addr_stb_o)); // R2
  AST_SW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && $past(state_o) == 3'd4) |-> (sw_len_q == {1'b0, ws_q} + 1'b1)); // R5
  AST_NO_S3_COMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && compress_i && !mem2mem_i) |=> (state_o == 3'd4)); // R6
  AST_M2M_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && mem2mem_i) |=> (state_o == 3'd3)); // R7
  AST_TC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o); // R8
  AST_STEP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd2)); // R9
  AST_S4_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !(rd_cmd_o || wr_cmd_o || addr_stb_o)); // R4
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.WW(WW)) i_chk (.*);

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
  localparam int TCK = 10;
  localparam int AW = 16, CW = 8, WW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, block = 0, m2m = 0, comp = 0, down = 0;
  logic [WW-1:0] wt = '0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] cnt = '0;
  logic [2:0] state;
  logic stb, rd, wr, tc, step;
  int checks = 0, errors = 0;

  always #(TCK/2) clk = ~clk;

  dma_xfer_seq #(.AW(AW), .CW(CW), .WW(WW)) i_dma_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .block_mode_i(block),
    .mem2mem_i(m2m), .compress_i(comp), .addr_down_i(down), .wait_i(wt),
    .addr_i(addr), .count_i(cnt), .state_o(state), .addr_stb_o(stb),
    .rd_cmd_o(rd), .wr_cmd_o(wr), .tc_o(tc), .step_o(step)
  );

  task automatic chk(input logic [2:0] es, input logic ers, ewr, estb, etc, estep,
                     input string tag);
    logic [7:0] act, exp;
    @(negedge clk);
    act = {state, rd, wr, stb, tc, step};
    exp = {es, ers, ewr, estb, etc, estep};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {state,rd,wr,stb,tc,step} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic run(input logic [AW-1:0] a0, input int n, input bit dn, cm, mm, blk,
                     input int ws, input int stop);
    bit eff = cm && !mm;
    bit need = 1'b1;
    bit last;
    @(negedge clk);
    addr = a0; cnt = CW'(n - 1); down = dn; comp = cm; m2m = mm; block = blk;
    wt = WW'(ws); req = 1'b1;
    for (int i = 0; i < n; i++) begin
      last = (cnt == 0);
      if (need) chk(3'd1, 0, 0, 1, 0, 0, "R3 S1 insert");
      chk(3'd2, 1, eff, 0, eff && last, 0, eff ? "R6 S2" : "R4 S2");
      if (!eff) chk(3'd3, 1, 1, 0, 0, 0, (cm && mm) ? "R7 S3" : "R4 S3");
      for (int w = 0; w <= ws; w++) chk(3'd4, 1, 1, 0, 0, 0, "R5 SW");
      chk(3'd5, 0, 0, 0, !eff && last, 1, "R8 R9 S4");
      need = dn ? (addr[7:0] == 8'h00) : (addr[7:0] == 8'hFF);
      addr = dn ? addr - 1'b1 : addr + 1'b1;
      cnt  = cnt - 1'b1;
      if (blk) req = 1'b0;                 // R10: must be ignored mid-run
      else if (last || i == stop) req = 1'b0;
      if (last || (!blk && i == stop)) break;
    end
    chk(3'd0, 0, 0, 0, 0, 0, blk ? "R10 end" : "R11 end");
  endtask

  initial begin
    #(TCK * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(TCK * 3);
    chk(3'd0, 0, 0, 0, 0, 0, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    chk(3'd0, 0, 0, 0, 0, 0, "R1 idle");
    for (int ws = 0; ws < 3; ws++)
      for (int cm = 0; cm < 2; cm++)
        for (int mm = 0; mm < 2; mm++)
          for (int dn = 0; dn < 2; dn++)
            for (int bk = 0; bk < 2; bk++)
              run(dn ? 16'h1302 : 16'h12FD, 5, dn[0], cm[0], mm[0], bk[0], ws,
                  (bk == 0 && mm == 1) ? 2 : 99);
    // R11: demand run stops early, then a fresh run re-inserts S1 (R2)
    run(16'h00FF, 4, 1'b0, 1'b1, 1'b0, 1'b0, 1, 0);
    run(16'h0080, 3, 1'b0, 1'b0, 1'b0, 1'b0, 0, 99);
    // R8: single-transfer runs in both timings
    run(16'h4000, 1, 1'b1, 1'b1, 1'b0, 1'b1, 0, 99);
    run(16'h4000, 1, 1'b1, 1'b0, 1'b0, 1'b1, 3, 99);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule